// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Pipeline Sequencer

This block times a small two-stage instruction pipeline. It divides the input clock into four phase slots, Q1 to Q4, which are exposed as one-hot strobes. Four slots make one instruction cycle. Each cycle fetches one 16-bit word from program memory while the word fetched in the previous cycle executes. The block holds the program counter, the fetch address, a prefetch latch and the instruction register. It issues a data-memory read strobe in Q2 and a write strobe in Q4 of every valid execute cycle.

Instruction decoding is reduced to a stub that flags branch opcodes. A branch is taken when the instruction executing is a branch and `br_req_i` is high in Q4. The word fetched behind the branch is then discarded and runs as an invalid bubble cycle. The branch target is fetched in the following cycle. A divided clock output rises at the start of each Q1.

Top module: `fx_pipe_seq`

## Requirements
- R1: `q_o` is one-hot with bit 0..3 meaning Q1..Q4. It advances one slot per input clock, wrapping from Q4 to Q1, and is in Q1 during the first slot after reset.
- R2: `clk_out_o` is high in Q1 and Q2 and low in Q3 and Q4, so its rising edge coincides with the start of Q1.
- R3: At the end of each Q1 slot, the fetch address `pmem_addr_o` takes the current program counter, or the pending branch target. `pc_o` becomes that address plus 2. Both hold for the rest of the instruction cycle.
- R4: The program word at `pmem_addr_o` is captured into the prefetch latch at the end of Q4. It moves into `ir_o` at the end of the next Q1, and `ir_o` does not change in any other slot.
- R5: `dmem_rd_o` pulses only in Q2 and `dmem_wr_o` only in Q4, and each only while `ex_valid_o` is high.
- R6: Without branches, instruction cycle m fetches address 2m. In cycle m, for m of 1 or more, `ir_o` holds the word from address 2(m-1) with `ex_valid_o` high.
- R7: Reset (active-low, asynchronous) clears the program counter, the fetch address and the pipeline. The first instruction cycle fetches address 0 with `ex_valid_o` low and no data strobes.
- R8: A branch is an instruction whose bits [15:12] equal 4'hC. If it executes validly with `br_req_i` high in Q4, the prefetched word is flushed, and the next cycle fetches `br_target_i` (sampled in Q4) with `ex_valid_o` low and no data strobes. The target word executes in the cycle after that.
- R9: `br_req_i` has no effect unless a valid branch opcode is executing. A branch opcode with `br_req_i` low continues sequentially, and a flushed word never branches, even if it carries a branch opcode.
- R10: `is_branch_o` is high exactly while a valid instruction with the branch opcode is in execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, one phase slot per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| q_o | output | 4 | One-hot phase strobes Q1..Q4 |
| clk_out_o | output | 1 | Clock divided by four, rising at Q1 |
| pmem_addr_o | output | ADDR_W | Program-memory fetch byte address |
| pmem_rdata_i | input | INSTR_W | Program word at the fetch address |
| br_req_i | input | 1 | Branch condition for the executing branch |
| br_target_i | input | ADDR_W | Branch target byte address |
| pc_o | output | ADDR_W | Program counter |
| ir_o | output | INSTR_W | Instruction register |
| ex_valid_o | output | 1 | Instruction register holds a real instruction |
| is_branch_o | output | 1 | Valid branch opcode executing |
| dmem_rd_o | output | 1 | Data-memory operand read strobe |
| dmem_wr_o | output | 1 | Data-memory destination write strobe |

## Verification
The bench uses the default 16-bit address and instruction widths with a 4-bit opcode field and branch code 4'hC. With these values, the bench can predict every fetch address and instruction word exactly from a program that encodes each word's own address. The branch opcode can be placed at any address, including on the word that a taken branch flushes. The bench runs short programs of about ten instruction cycles from reset. These cover the reset fetch-only cycle, straight-line flow, a taken branch with its bubble, and a branch opcode whose request is low.

// File: rtl/fx_pipe_pkg.sv
package fx_pipe_pkg;
  localparam int NUM_PH = 4;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
endpackage

// File: rtl/fx_phase_gen.sv
module fx_phase_gen
  import fx_pipe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output phase_e            ph_o,
  output logic [NUM_PH-1:0] q_o,
  output logic              clk_out_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_Q1;
    else         ph_q <= phase_e'(ph_q + 2'd1);
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_strobe
    assign q_o[g] = (ph_q == phase_e'(g));
  end

  assign clk_out_o = (ph_q == PH_Q1) || (ph_q == PH_Q2);
  assign ph_o      = ph_q;
endmodule

// File: rtl/fx_fetch.sv
module fx_fetch
  import fx_pipe_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  phase_e             ph_i,
  input  logic               taken_i,
  input  logic [ADDR_W-1:0]  target_i,
  input  logic [INSTR_W-1:0] rdata_i,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] pf_word_o,
  output logic               pf_valid_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_q, fa_q, tgt_q, nxt;
  logic              pend_q;

  assign nxt = pend_q ? tgt_q : pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      fa_q       <= '0;
      tgt_q      <= '0;
      pend_q     <= 1'b0;
      pf_word_o  <= '0;
      pf_valid_o <= 1'b0;
    end else begin
      unique case (ph_i)
        PH_Q1: begin
          fa_q   <= nxt;
          pc_q   <= nxt + STEP;
          pend_q <= 1'b0;
        end
        PH_Q4: begin
          pf_word_o  <= rdata_i;
          pf_valid_o <= !taken_i;  // flush the word behind a taken branch
          if (taken_i) begin
            pend_q <= 1'b1;
            tgt_q  <= target_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign fetch_addr_o = fa_q;
  assign pc_o         = pc_q;
endmodule

// File: rtl/fx_exec.sv
module fx_exec
  import fx_pipe_pkg::*;
#(
  parameter int          INSTR_W   = 16,
  parameter int          OPC_W     = 4,
  parameter logic [OPC_W-1:0] BR_OPCODE = 4'hC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  phase_e             ph_i,
  input  logic [INSTR_W-1:0] pf_word_i,
  input  logic               pf_valid_i,
  input  logic               br_req_i,
  output logic [INSTR_W-1:0] ir_o,
  output logic               valid_o,
  output logic               is_branch_o,
  output logic               taken_o,
  output logic               rd_o,
  output logic               wr_o
);
  logic [OPC_W-1:0] opc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_o    <= '0;
      valid_o <= 1'b0;
    end else if (ph_i == PH_Q1) begin
      ir_o    <= pf_word_i;
      valid_o <= pf_valid_i;
    end
  end

  assign opc         = ir_o[INSTR_W-1 -: OPC_W];
  assign is_branch_o = valid_o && (opc == BR_OPCODE);
  assign taken_o     = is_branch_o && br_req_i && (ph_i == PH_Q4);
  assign rd_o        = valid_o && (ph_i == PH_Q2);
  assign wr_o        = valid_o && (ph_i == PH_Q4);
endmodule

// File: rtl/fx_pipe_seq.sv
module fx_pipe_seq
  import fx_pipe_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter logic [OPC_W-1:0] BR_OPCODE = 4'hC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [3:0]         q_o,
  output logic               clk_out_o,
  output logic [ADDR_W-1:0]  pmem_addr_o,
  input  logic [INSTR_W-1:0] pmem_rdata_i,
  input  logic               br_req_i,
  input  logic [ADDR_W-1:0]  br_target_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               ex_valid_o,
  output logic               is_branch_o,
  output logic               dmem_rd_o,
  output logic               dmem_wr_o
);
  phase_e             ph;
  logic [INSTR_W-1:0] pf_word;
  logic               pf_valid;
  logic               taken;

  fx_phase_gen u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(ph), .q_o(q_o), .clk_out_o(clk_out_o)
  );

  fx_fetch #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_i(ph), .taken_i(taken),
    .target_i(br_target_i), .rdata_i(pmem_rdata_i), .fetch_addr_o(pmem_addr_o),
    .pc_o(pc_o), .pf_word_o(pf_word), .pf_valid_o(pf_valid)
  );

  fx_exec #(.INSTR_W(INSTR_W), .OPC_W(OPC_W), .BR_OPCODE(BR_OPCODE)) u_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_i(ph), .pf_word_i(pf_word),
    .pf_valid_i(pf_valid), .br_req_i(br_req_i), .ir_o(ir_o), .valid_o(ex_valid_o),
    .is_branch_o(is_branch_o), .taken_o(taken), .rd_o(dmem_rd_o), .wr_o(dmem_wr_o)
  );
endmodule

// File: rtl/fx_pipe_seq_chk.sv
module fx_pipe_seq_chk #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [3:0]         q_o,
  input logic               clk_out_o,
  input logic [ADDR_W-1:0]  pmem_addr_o,
  input logic               br_req_i,
  input logic [ADDR_W-1:0]  br_target_i,
  input logic [ADDR_W-1:0]  pc_o,
  input logic [INSTR_W-1:0] ir_o,
  input logic               ex_valid_o,
  input logic               is_branch_o,
  input logic               dmem_rd_o,
  input logic               dmem_wr_o
);
  AST_ONE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q_o) == 1);  // R1
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[3] |=> q_o[0]);  // R1
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o[0] |=> q_o[1]);  // R1
  AST_CLKOUT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_out_o) |-> q_o[0]);  // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o[0] |=> ($stable(pc_o) && $stable(pmem_addr_o)));  // R3
  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o[0] |=> $stable(ir_o));  // R4
  AST_RD_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_rd_o |-> (q_o[1] && ex_valid_o));  // R5
  AST_WR_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_wr_o |-> (q_o[3] && ex_valid_o));  // R5
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && is_branch_o && br_req_i) |=> ##1
      (!ex_valid_o && pmem_addr_o == $past(br_target_i, 2)));  // R8
  AST_BR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_branch_o |-> ex_valid_o);  // R10
endmodule

bind fx_pipe_seq fx_pipe_seq_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .q_o(q_o), .clk_out_o(clk_out_o),
  .pmem_addr_o(pmem_addr_o), .br_req_i(br_req_i), .br_target_i(br_target_i),
  .pc_o(pc_o), .ir_o(ir_o), .ex_valid_o(ex_valid_o), .is_branch_o(is_branch_o),
  .dmem_rd_o(dmem_rd_o), .dmem_wr_o(dmem_wr_o)
);

// File: tb/fx_pipe_seq_bench.sv
module fx_pipe_seq_bench;
  localparam int AW = 16;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    q;
  logic          clk_out;
  logic [AW-1:0] paddr, pc, tgt;
  logic [IW-1:0] prdata, ir;
  logic          br_req, ex_valid, is_br, drd, dwr;

  int checks = 0, fails = 0, slot = 0;
  bit done = 0;
  logic [AW-1:0] ba0 = 16'hFFFF, ba1 = 16'hFFFF;

  always #4 clk = ~clk;

  fx_pipe_seq u_fx_pipe_seq (
    .clk_i(clk), .rst_ni(rst_n), .q_o(q), .clk_out_o(clk_out), .pmem_addr_o(paddr),
    .pmem_rdata_i(prdata), .br_req_i(br_req), .br_target_i(tgt), .pc_o(pc), .ir_o(ir),
    .ex_valid_o(ex_valid), .is_branch_o(is_br), .dmem_rd_o(drd), .dmem_wr_o(dwr)
  );

  function automatic logic [IW-1:0] mem(input logic [AW-1:0] a);
    return ((a == ba0) || (a == ba1)) ? {4'hC, a[11:0]} : {4'h1, a[11:0]};
  endfunction

  always_comb prdata = mem(paddr);

  always @(posedge clk) begin
    if (!rst_n) slot <= 0;
    else        slot <= slot + 1;
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s slot=%0d got=%h exp=%h", req, slot, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic go(input int s);
    while (slot < s) @(negedge clk);
  endtask

  // instruction cycle m, straight-line expectations at Q2 and Q4
  task automatic seq_cycle(input int m, input string req);
    go(4*m + 1);
    chk(paddr, 2*m, req);
    chk(pc, 2*m + 2, req);
    chk(ex_valid, m >= 1, req);
    if (m >= 1) chk(ir, mem(AW'(2*(m-1))), req);
    chk(drd, m >= 1, "R5");
    go(4*m + 2);
    chk({drd, dwr}, 2'b00, "R5");
    go(4*m + 3);
    chk(dwr, m >= 1, "R5");
  endtask

  task automatic t_reset();
    br_req = 0; tgt = 0; ba0 = 16'hFFFF; ba1 = 16'hFFFF;
    do_reset();
    chk(q, 4'b0001, "R7");
    chk(paddr, 0, "R7");
    chk(pc, 0, "R7");
    chk({ex_valid, drd, dwr, is_br}, 0, "R7");
    for (int m = 0; m < 1; m++) seq_cycle(m, "R7");
  endtask

  task automatic t_phase();
    br_req = 0; do_reset();
    for (int s = 0; s < 8; s++) begin
      go(s);
      chk(q, 4'b0001 << (s % 4), "R1");
      chk(clk_out, (s % 4) < 2, "R2");
    end
  endtask

  task automatic t_seq();
    // br_req held high with no branch opcode: R9
    br_req = 1; tgt = 16'h0040; ba0 = 16'hFFFF; ba1 = 16'hFFFF;
    do_reset();
    for (int m = 0; m < 8; m++) begin
      seq_cycle(m, "R6");
      go(4*m + 1);
      chk(is_br, 0, "R9");
    end
    go(4*8);
    chk(ir, mem(16'd12), "R4");  // Q1 of cycle 8: ir still old word
  endtask

  task automatic t_branch();
    br_req = 1; tgt = 16'h0040; ba0 = 16'd6; ba1 = 16'd8;  // flushed word is a branch too
    do_reset();
    for (int m = 0; m < 4; m++) seq_cycle(m, "R6");
    go(17);
    chk(is_br, 1, "R10");
    chk(ir, mem(16'd6), "R8");
    go(21);
    chk(paddr, 16'h0040, "R8");
    chk(pc, 16'h0042, "R3");
    chk({ex_valid, drd, is_br}, 0, "R8");
    go(23);
    chk(dwr, 0, "R8");
    go(25);
    chk(ex_valid, 1, "R8");
    chk(ir, mem(16'h0040), "R8");
    chk(paddr, 16'h0042, "R9");
    go(29);
    chk(ir, mem(16'h0042), "R8");
    chk(paddr, 16'h0044, "R3");
  endtask

  task automatic t_nobranch();
    br_req = 0; tgt = 16'h0040; ba0 = 16'd6; ba1 = 16'hFFFF;
    do_reset();
    for (int m = 0; m < 4; m++) seq_cycle(m, "R9");
    go(17);
    chk(is_br, 1, "R10");
    go(21);
    chk(paddr, 16'd10, "R9");
    chk(ex_valid, 1, "R9");
    chk(ir, mem(16'd8), "R9");
  endtask

  initial begin
    br_req = 0; tgt = 0;
    t_reset();
    t_phase();
    t_seq();
    t_branch();
    t_nobranch();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule